// File: doc/BRIEF.md
# Batch-Based Anti-Starvation Filter

This block sits next to a multi-bank request arbiter and keeps a bank that is always ready from locking the other banks out. Each cycle it sees which bank queues hold work and which bank the arbiter served. From these it keeps a set of "old" marks, one per bank, and an age counter for the group of marked banks. Its only output is a per-bank permit mask, which the arbiter ANDs into its request vector.

When no bank carries a mark, the filter takes a snapshot. Every bank with queued work gets a mark, except a bank that is issuing in that same cycle, and the age counter returns to zero. While marks remain, the counter climbs by one per cycle and holds at its maximum value. Once it passes twice the bank busy time, only marked banks keep their permit, so the old group drains before newer work is served. A fixed-delay mode input opens the mask completely.

Top module: `age_batch_gate`

## Requirements
- R1: After reset, no bank carries a mark, the age is zero and permit_o is all ones.
- R2: On a clock edge where no mark is set, bank b becomes marked exactly when q_nonempty_i[b] is 1 and issued_i[b] is 0, and the age becomes zero.
- R3: A bank whose issued_i bit is 1 on an edge has no mark after that edge, and no new mark appears while any mark is set.
- R4: While any mark is set, the age increases by one on every edge. With one bank issuing on every cycle, it keeps permission for exactly 2*BUSY_CYCLES+2 consecutive edges, counted from the snapshot edge.
- R5: Bit b of permit_o belongs to bank b. When fixed_delay_i is 0, some mark is set and the age exceeds 2*BUSY_CYCLES, permit_o equals the mark vector. Otherwise permit_o is all ones.
- R6: While fixed_delay_i is 1, permit_o is all ones in the same cycle. Returning it to 0 restores the gated mask without any loss of state.
- R7: The age counter, ceil(log2(2*BUSY_CYCLES+2)) bits wide, saturates rather than wraps. A marked bank that never issues keeps unmarked banks denied for any length of time.
- R8: permit_o depends only on registered state and fixed_delay_i. A change on issued_i or q_nonempty_i does not alter it before the next edge.
- R9: When one bank is always ready and always wins, a second bank that is queued at snapshot time issues within 2*BUSY_CYCLES+3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fixed_delay_i | input | 1 | Bypass: opens every permit bit |
| q_nonempty_i | input | NUM_BANKS | Bank queue holds at least one request |
| issued_i | input | NUM_BANKS | Bank was served by the arbiter this cycle |
| permit_o | output | NUM_BANKS | Bank may be considered for issue |

## Verification
The assertions assume that issued_i is sampled with the other inputs on the clock edge and has the same meaning in every cycle. Several of them also assume that the arbiter serves only banks that have queued work and are permitted. The bench keeps within these assumptions. Its arbiter is a behavioural model that drives issued_i at the falling edge. It chooses at most one bank, and only from q_nonempty_i AND permit_o. Banks can be withheld on purpose to force saturation. A second behavioural model of the marks and the unbounded age predicts permit_o on every cycle. Directed cases cover the hog/victim race, a stuck marked bank and the bypass input.

// File: rtl/abg_pkg.sv
`timescale 1ns/1ps
package abg_pkg;
  // Gate closes once age exceeds this value.
  function automatic int gate_limit(input int busy_cycles);
    return 2 * busy_cycles;
  endfunction

  // Counter wide enough to hold a value past the limit.
  function automatic int age_bits(input int busy_cycles);
    return $clog2(2 * busy_cycles + 2);
  endfunction
endpackage

// File: rtl/abg_flags.sv
`timescale 1ns/1ps
module abg_flags #(
  parameter int NB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] nonempty_i,
  input  logic [NB-1:0] issued_i,
  output logic [NB-1:0] old_o,
  output logic          any_old_o
);
  logic [NB-1:0] old_q, old_d;

  always_comb begin
    if (|old_q) old_d = old_q & ~issued_i;
    else        old_d = nonempty_i & ~issued_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) old_q <= '0;
    else        old_q <= old_d;
  end

  assign old_o     = old_q;
  assign any_old_o = |old_q;
endmodule

// File: rtl/abg_age.sv
`timescale 1ns/1ps
module abg_age #(
  parameter int AGE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  output logic [AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age_q, age_d;
  logic             age_en;

  always_comb begin
    age_en = restart_i | (age_q != AGE_MAX);
    age_d  = restart_i ? '0 : age_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (age_en) age_q <= age_d;
  end

  assign age_o = age_q;
endmodule

// File: rtl/abg_mask.sv
`timescale 1ns/1ps
module abg_mask #(
  parameter int NB     = 8,
  parameter int AGE_W  = 4,
  parameter int THRESH = 8
) (
  input  logic             fixed_i,
  input  logic             any_old_i,
  input  logic [NB-1:0]    old_i,
  input  logic [AGE_W-1:0] age_i,
  output logic [NB-1:0]    permit_o
);
  logic open_all;

  assign open_all = fixed_i | ~any_old_i | (age_i <= AGE_W'(THRESH));

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign permit_o[b] = open_all | old_i[b];
  end
endmodule

// File: rtl/age_batch_gate.sv
`timescale 1ns/1ps
module age_batch_gate #(
  parameter int NUM_BANKS   = 8,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fixed_delay_i,
  input  logic [NUM_BANKS-1:0] q_nonempty_i,
  input  logic [NUM_BANKS-1:0] issued_i,
  output logic [NUM_BANKS-1:0] permit_o
);
  localparam int THRESH = abg_pkg::gate_limit(BUSY_CYCLES);
  localparam int AGE_W  = abg_pkg::age_bits(BUSY_CYCLES);

  logic [1:0]           rst_sync_q;
  logic                 rst_sync_n;
  logic [NUM_BANKS-1:0] old_q;
  logic                 any_old;
  logic [AGE_W-1:0]     age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  abg_flags #(.NB(NUM_BANKS)) u_flags (
    .clk(clk), .rst_n(rst_sync_n),
    .nonempty_i(q_nonempty_i), .issued_i(issued_i),
    .old_o(old_q), .any_old_o(any_old)
  );

  abg_age #(.AGE_W(AGE_W)) u_age (
    .clk(clk), .rst_n(rst_sync_n),
    .restart_i(~any_old), .age_o(age_q)
  );

  abg_mask #(.NB(NUM_BANKS), .AGE_W(AGE_W), .THRESH(THRESH)) u_mask (
    .fixed_i(fixed_delay_i), .any_old_i(any_old),
    .old_i(old_q), .age_i(age_q), .permit_o(permit_o)
  );
endmodule

// File: rtl/abg_checker.sv
`timescale 1ns/1ps
module abg_checker #(
  parameter int NB     = 8,
  parameter int AGE_W  = 4,
  parameter int THRESH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fixed_i,
  input logic [NB-1:0]    nonempty_i,
  input logic [NB-1:0]    issued_i,
  input logic [NB-1:0]    old_q,
  input logic [AGE_W-1:0] age_q,
  input logic [NB-1:0]    permit_o
);
  a_r2_snapshot_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (old_q == '0) |=> (old_q == ($past(nonempty_i) & ~$past(issued_i))));

  a_r2_snapshot_age: assert property (@(posedge clk) disable iff (!rst_n)
    (old_q == '0) |=> (age_q == '0));

  a_r3_issue_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (issued_i != '0) |=> ((old_q & $past(issued_i)) == '0));

  a_r3_no_late_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (old_q != '0) |=> ((old_q & ~$past(old_q)) == '0));

  a_r4_age_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((old_q != '0) && (age_q != '1)) |=> (age_q == AGE_W'($past(age_q) + 1'b1)));

  a_r7_age_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((old_q != '0) && (age_q == '1)) |=> (age_q == '1));

  a_r5_open_when_young: assert property (@(posedge clk) disable iff (!rst_n)
    ((old_q == '0) || (age_q <= AGE_W'(THRESH))) |-> (permit_o == '1));

  a_r5_closed_to_new: assert property (@(posedge clk) disable iff (!rst_n)
    (!fixed_i && (old_q != '0) && (age_q > AGE_W'(THRESH))) |-> ((permit_o & ~old_q) == '0));

  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_i |-> (permit_o == '1));
endmodule

bind age_batch_gate abg_checker #(.NB(NUM_BANKS), .AGE_W(AGE_W), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .fixed_i(fixed_delay_i),
  .nonempty_i(q_nonempty_i), .issued_i(issued_i),
  .old_q(old_q), .age_q(age_q), .permit_o(permit_o)
);

// File: tb/age_batch_gate_tb.sv
`timescale 1ns/1ps
module age_batch_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 8;
  localparam int BUSY = 4;
  localparam int T    = 2 * BUSY;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fx;
  logic [NB-1:0] q_nonempty, issued, permit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int            cnt [NB];
  logic [NB-1:0] hold;
  logic [NB-1:0] m_old;
  int            m_age;
  int            start;
  logic [NB-1:0] last_iss, last_perm;
  logic [15:0]   lfsr;

  always #(CLK_PERIOD/2) clk = ~clk;

  age_batch_gate #(.NUM_BANKS(NB), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .fixed_delay_i(fx),
    .q_nonempty_i(q_nonempty), .issued_i(issued), .permit_o(permit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] model_permit();
    if (fx || m_old == '0 || m_age <= T) return '1;
    return m_old;
  endfunction

  task automatic step();
    logic [NB-1:0] ne, cand, iss, pb;
    @(negedge clk);
    chk(permit == model_permit(), "R5", "permit vs model", permit, model_permit());
    pb = permit;
    for (int b = 0; b < NB; b++) ne[b] = (cnt[b] > 0);
    cand = ne & permit & ~hold;
    iss = '0;
    for (int k = 0; k < NB; k++) begin
      int b;
      b = (start + k) % NB;
      if (iss == '0 && cand[b]) iss[b] = 1'b1;
    end
    q_nonempty = ne;
    issued = iss;
    #1;
    chk(permit == pb, "R8", "permit moved before edge", permit, pb);
    last_iss = iss;
    last_perm = pb;
    @(posedge clk);
    if (m_old == '0) begin
      m_old = ne & ~iss;
      m_age = 0;
    end else begin
      m_old = m_old & ~iss;
      if (m_age < 100000) m_age++;
    end
    for (int b = 0; b < NB; b++) if (iss[b]) cnt[b]--;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n0, steps;
    bit seen3;
    rst_n = 1'b0; fx = 1'b0; q_nonempty = '0; issued = '0;
    hold = '0; m_old = '0; m_age = 0; start = 0; lfsr = 16'hACE1;
    for (int b = 0; b < NB; b++) cnt[b] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) step();
    chk(permit == '1, "R1", "permit after reset", permit, '1);

    // Hog on bank 0, victim on bank 3
    cnt[0] = 1000; cnt[3] = 1;
    n0 = 0; steps = 0; seen3 = 0;
    while (!seen3 && steps < 50) begin
      step();
      steps++;
      if (last_iss[0]) n0++;
      if (last_iss[3]) seen3 = 1;
    end
    chk(n0 == T + 2, "R4", "hog issues before gate closed", n0, T + 2);
    chk(seen3 && steps <= T + 3, "R9", "victim issue step", steps, T + 3);
    chk(last_perm == 8'b0000_1000, "R2", "mask while gate closed", last_perm, 8'h08);
    chk(permit == '1, "R3", "open after last mark issued", permit, '1);
    cnt[0] = 0;
    repeat (4) step();

    // Stuck marked bank 5, hog bank 0: saturation
    cnt[0] = 1000; cnt[5] = 1; hold = 8'b0010_0000;
    repeat (40) step();
    chk(permit == 8'b0010_0000, "R7", "gate still closed after long wait", permit, 8'h20);
    fx = 1'b1; #1;
    chk(permit == '1, "R6", "bypass opens mask", permit, '1);
    fx = 1'b0; #1;
    chk(permit == 8'b0010_0000, "R6", "gated mask restored", permit, 8'h20);
    hold = '0;
    step();
    chk(last_iss == 8'b0010_0000, "R5", "only marked bank served", last_iss, 8'h20);
    chk(permit == '1, "R3", "mark cleared by issue", permit, '1);
    cnt[0] = 0;
    repeat (3) step();

    // Mixed traffic with rotating priority
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) cnt[lfsr[3:1]]++;
      if (lfsr[4] && lfsr[5]) cnt[0] += 2;
      hold = (lfsr[7:6] == 2'b00) ? {lfsr[15:12], lfsr[11:8]} & 8'h3C : '0;
      fx = (lfsr[11:8] == 4'h0);
      start = (start + (lfsr[9] ? 1 : 0)) % NB;
      step();
    end
    fx = 1'b0; #1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule